// File: doc/BRIEF.md
# Cache Performance Counter Bank

This block is a bank of hardware event counters for a cache cluster. It has a parameterised number of 32-bit event counters, one to eight, and one 64-bit cycle counter. Software reaches every register through two ports. It first writes a 12-bit address into a select register. It then reads or writes the data register, which forwards the access to the selected address. Each event counter advances on a one-cycle increment pulse from the cache pipeline. The cycle counter advances on every clock while it is enabled.

Each counter has three per-counter bits: a count enable, an interrupt enable and an overflow flag. Each group of bits is a 32-bit mask with one address that sets bits and one that clears them. Bit n belongs to event counter n and bit 31 belongs to the cycle counter. A control register holds the global run bit and resets the counters. It also reports how many event counters the bank was built with. A counter that wraps past its all-ones value sets its overflow flag. The single interrupt line is high while any flagged counter has its interrupt enabled.

Top module: `evb_top`

## Requirements
- R1: After reset, all counters, masks and count-control registers are zero, the global run bit is clear, and `irq` and `rvalid` are low.
- R2: A pulse on `sel_we` latches `wdata[11:0]` as the target address. A pulse on `data_re` returns the target's contents on `rdata`, with `rvalid` high for exactly the following cycle. Addresses that are not mapped read zero and ignore writes. If `sel_we` and `data_we` are high in the same cycle, the data write uses the address that was latched before.
- R3: Address 0x400 reads the global run bit at bit 0 and the event counter count NUM_EV at bits 15:11. All its other bits read zero.
- R4: A write to 0x400 loads the run bit from `wdata[0]`. The same write clears all event counters if `wdata[1]` is set, and clears the cycle counter if `wdata[2]` is set, so 0x6 clears both. Bits 1 and 2 are not stored.
- R5: Writing ones to 0x404 sets count-enable bits and writing ones to 0x403 clears them. Both addresses read the mask. Only bits 0..NUM_EV-1 and bit 31 exist; every other bit reads zero.
- R6: The interrupt-enable mask follows the same scheme as R5, with its set address at 0x406 and its clear address at 0x405.
- R7: Event counter n, whose value is at 0x421 + 0x10·n, adds one on each cycle in which `ev_inc[n]` is high, but only while both the run bit and count-enable bit n are set.
- R8: The cycle counter at 0x40A is 64 bits wide. It adds one on every cycle while both the run bit and count-enable bit 31 are set.
- R9: A write to a counter's value address loads that counter. A load takes precedence over an increment in the same cycle.
- R10: An event counter stepping from 0xFFFFFFFF to 0 sets overflow bit n. The cycle counter stepping from all ones to 0 sets overflow bit 31.
- R11: Overflow status reads at both 0x408 and 0x407. Writing ones to 0x408 sets bits and writing ones to 0x407 clears them. A wrap in the same cycle as a clear leaves the bit set.
- R12: `irq` is the OR over all counters of overflow status AND interrupt enable. It is driven directly from the registered masks.
- R13: Address 0x420 + 0x10·n holds a 32-bit count-control register for event counter n. It reads back what was written and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Latch `wdata[11:0]` as the target address |
| data_we | input | 1 | Write `wdata` to the target address |
| data_re | input | 1 | Read the target address |
| wdata | input | 64 | Write data for both ports |
| rdata | output | 64 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | Read response strobe, one cycle after `data_re` |
| ev_inc | input | NUM_EV | Per-counter increment pulses |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the bank with NUM_EV = 4. This makes the count field read back as 0x2000. The address slot of counter 4 (0x461) is then unmapped, which exercises the unmapped-address path. Mask bits 4 to 30 also become unimplemented, so the bench can show that setting all ones reads back as 0x8000000F. Preloads just below the wrap point let the bench trigger both the 32-bit and the 64-bit overflow within a few cycles. The cycle counter's exact value is predicted from the number of clock edges that fall between the run-bit writes.

// File: rtl/evb_pkg.sv
package evb_pkg;

    localparam int unsigned AW      = 12;   // indirect address width
    localparam int unsigned DW      = 64;   // data port width
    localparam int unsigned MW      = 32;   // per-counter mask width
    localparam int unsigned EW      = 32;   // event counter width
    localparam int unsigned CW      = 64;   // cycle counter width
    localparam int unsigned CYC_BIT = 31;   // cycle counter slot in every mask
    localparam int unsigned NEV_LSB = 11;   // counter-count field in control
    localparam int unsigned NEV_W   = 5;

    localparam logic [AW-1:0] A_CTRL    = 12'h400;
    localparam logic [AW-1:0] A_CEN_CLR = 12'h403;
    localparam logic [AW-1:0] A_CEN_SET = 12'h404;
    localparam logic [AW-1:0] A_IEN_CLR = 12'h405;
    localparam logic [AW-1:0] A_IEN_SET = 12'h406;
    localparam logic [AW-1:0] A_OVS_CLR = 12'h407;
    localparam logic [AW-1:0] A_OVS_SET = 12'h408;
    localparam logic [AW-1:0] A_CYC     = 12'h40A;
    // per-counter rows start at 0x420, 0x10 apart; offset 0 control, 1 value
    localparam logic [AW-5:0] EV_ROW0   = 8'h42;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_CTRL,
        RS_CEN,
        RS_IEN,
        RS_OVS,
        RS_CYC,
        RS_EVVAL,
        RS_EVCCR
    } rsel_e;

    // Implemented bits of a mask: the event slots plus the cycle slot.
    function automatic logic [MW-1:0] valid_mask(input int unsigned nev);
        logic [MW-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < CYC_BIT; i++) begin
            if (i < nev) m[i] = 1'b1;
        end
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/evb_regport.sv
module evb_regport
    import evb_pkg::*;
#(
    parameter int unsigned NUM_EV = 8,
    localparam int unsigned IDXW  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_we,
    input  logic [AW-1:0]   sel_addr,
    output rsel_e           rsel,
    output logic [IDXW-1:0] ev_idx
);

    localparam logic [AW-5:0] NEV_ROWS = (AW-4)'(NUM_EV);

    logic [AW-1:0] sel_d, sel_q;
    logic [AW-5:0] row;

    always_comb begin
        sel_d = sel_q;
        if (sel_we) sel_d = sel_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign row = sel_q[AW-1:4] - EV_ROW0;

    always_comb begin
        rsel   = RS_NONE;
        ev_idx = '0;
        case (sel_q)
            A_CTRL:                 rsel = RS_CTRL;
            A_CEN_CLR, A_CEN_SET:   rsel = RS_CEN;
            A_IEN_CLR, A_IEN_SET:   rsel = RS_IEN;
            A_OVS_CLR, A_OVS_SET:   rsel = RS_OVS;
            A_CYC:                  rsel = RS_CYC;
            default: begin
                if ((sel_q[AW-1:4] >= EV_ROW0) && (row < NEV_ROWS)
                    && (sel_q[3:1] == 3'b000)) begin
                    rsel   = sel_q[0] ? RS_EVVAL : RS_EVCCR;
                    ev_idx = row[IDXW-1:0];
                end
            end
        endcase
    end

endmodule

// File: rtl/evb_ctr.sv
module evb_ctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

endmodule

// File: rtl/evb_top.sv
module evb_top
    import evb_pkg::*;
#(
    parameter int unsigned NUM_EV = 8,
    localparam int unsigned IDXW  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rvalid,
    input  logic [NUM_EV-1:0] ev_inc,
    output logic              irq
);

    localparam logic [MW-1:0] VMASK = valid_mask(NUM_EV);

    typedef struct packed {
        logic          en;
        logic [MW-1:0] cen;
        logic [MW-1:0] ien;
        logic [MW-1:0] ovs;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [EW-1:0] ccr_d [NUM_EV];
    logic [EW-1:0] ccr_q [NUM_EV];

    rsel_e           rsel;
    logic [IDXW-1:0] ev_idx;

    logic [EW-1:0]     ev_val [NUM_EV];
    logic [NUM_EV-1:0] ev_step, ev_load, ev_wrap;
    logic [CW-1:0]     cyc_val;
    logic              cyc_step, cyc_load, cyc_clr, cyc_wrap;
    logic              ev_clr;
    logic              hit_ctrl, hit_ovs_clr, hit_ovs_set;
    logic              glb_en;
    logic [MW-1:0]     ovs_mask;
    logic [MW-1:0]     wmask, wrap_bits;
    logic [DW-1:0]     rd_mux;

    evb_regport #(.NUM_EV(NUM_EV)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (sel_we),
        .sel_addr (wdata[AW-1:0]),
        .rsel     (rsel),
        .ev_idx   (ev_idx)
    );

    // The set and clear addresses of a mask are told apart by the low address bits.
    logic [AW-1:0] sel_shadow_d, sel_shadow_q;
    always_comb begin
        sel_shadow_d = sel_shadow_q;
        if (sel_we) sel_shadow_d = wdata[AW-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_shadow_q <= '0;
        else        sel_shadow_q <= sel_shadow_d;
    end

    assign wmask       = wdata[MW-1:0] & VMASK;
    assign hit_ctrl    = data_we && (rsel == RS_CTRL);
    assign hit_ovs_clr = data_we && (rsel == RS_OVS) && (sel_shadow_q == A_OVS_CLR);
    assign hit_ovs_set = data_we && (rsel == RS_OVS) && (sel_shadow_q == A_OVS_SET);
    assign ev_clr      = hit_ctrl && wdata[1];
    assign cyc_clr     = hit_ctrl && wdata[2];
    assign cyc_load    = data_we && (rsel == RS_CYC);
    assign cyc_step    = st_q.en && st_q.cen[CYC_BIT];

    for (genvar n = 0; n < NUM_EV; n++) begin : g_ev
        assign ev_step[n] = st_q.en && st_q.cen[n] && ev_inc[n];
        assign ev_load[n] = data_we && (rsel == RS_EVVAL) && (ev_idx == IDXW'(n));
        evb_ctr #(.W(EW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (ev_step[n]),
            .clr      (ev_clr),
            .load     (ev_load[n]),
            .load_val (wdata[EW-1:0]),
            .value    (ev_val[n]),
            .wrap     (ev_wrap[n])
        );
    end

    evb_ctr #(.W(CW)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cyc_step),
        .clr      (cyc_clr),
        .load     (cyc_load),
        .load_val (wdata[CW-1:0]),
        .value    (cyc_val),
        .wrap     (cyc_wrap)
    );

    always_comb begin
        wrap_bits              = '0;
        wrap_bits[NUM_EV-1:0]  = ev_wrap;
        wrap_bits[CYC_BIT]     = cyc_wrap;
    end

    always_comb begin
        rd_mux = '0;
        case (rsel)
            RS_CTRL: begin
                rd_mux[0]                 = st_q.en;
                rd_mux[NEV_LSB +: NEV_W]  = NEV_W'(NUM_EV);
            end
            RS_CEN:   rd_mux[MW-1:0] = st_q.cen;
            RS_IEN:   rd_mux[MW-1:0] = st_q.ien;
            RS_OVS:   rd_mux[MW-1:0] = st_q.ovs;
            RS_CYC:   rd_mux         = cyc_val;
            RS_EVVAL: rd_mux[EW-1:0] = ev_val[ev_idx];
            RS_EVCCR: rd_mux[EW-1:0] = ccr_q[ev_idx];
            default:  rd_mux         = '0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        ccr_d  = ccr_q;
        st_d.rvalid = data_re;
        if (data_re) st_d.rdata = rd_mux;
        if (hit_ctrl) st_d.en = wdata[0];
        if (data_we && (rsel == RS_CEN)) begin
            if (sel_shadow_q == A_CEN_SET) st_d.cen = st_q.cen | wmask;
            else                           st_d.cen = st_q.cen & ~wmask;
        end
        if (data_we && (rsel == RS_IEN)) begin
            if (sel_shadow_q == A_IEN_SET) st_d.ien = st_q.ien | wmask;
            else                           st_d.ien = st_q.ien & ~wmask;
        end
        st_d.ovs = (st_q.ovs & ~(hit_ovs_clr ? wmask : '0))
                 | (hit_ovs_set ? wmask : '0)
                 | wrap_bits;
        if (data_we && (rsel == RS_EVCCR)) ccr_d[ev_idx] = wdata[EW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_EV; i++) ccr_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            ccr_q <= ccr_d;
        end
    end

    assign glb_en   = st_q.en;
    assign ovs_mask = st_q.ovs;
    assign irq      = |(st_q.ovs & st_q.ien);
    assign rdata    = st_q.rdata;
    assign rvalid   = st_q.rvalid;

endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
    parameter int unsigned NUM_EV = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_re,
    input logic              data_we,
    input logic              rvalid,
    input logic              irq,
    input logic              glb_en,
    input logic [63:0]       cyc_val,
    input logic              cyc_load,
    input logic              cyc_clr,
    input logic              cyc_wrap,
    input logic [NUM_EV-1:0] ev_wrap,
    input logic [31:0]       ovs_mask,
    input logic              hit_ovs_clr,
    input logic [63:0]       wdata
);

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_re |=> rvalid);

    // R2
    no_spur_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_re |=> !rvalid);

    // R8
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_load && !cyc_clr) |=> ((cyc_val == $past(cyc_val) + 64'd1) || $stable(cyc_val)));

    // R8
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cyc_load && !cyc_clr) |=> $stable(cyc_val));

    // R10
    ev_wrap_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_wrap) |=> ((ovs_mask[NUM_EV-1:0] & $past(ev_wrap)) == $past(ev_wrap)));

    // R10
    cyc_wrap_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wrap |=> ovs_mask[31]);

    // R11
    ovs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ovs_clr && wdata[0] && !ev_wrap[0]) |=> !ovs_mask[0]);

    // R12
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(data_we) || $past(|ev_wrap) || $past(cyc_wrap)));

endmodule

bind evb_top evb_chk #(.NUM_EV(NUM_EV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_re     (data_re),
    .data_we     (data_we),
    .rvalid      (rvalid),
    .irq         (irq),
    .glb_en      (glb_en),
    .cyc_val     (cyc_val),
    .cyc_load    (cyc_load),
    .cyc_clr     (cyc_clr),
    .cyc_wrap    (cyc_wrap),
    .ev_wrap     (ev_wrap),
    .ovs_mask    (ovs_mask),
    .hit_ovs_clr (hit_ovs_clr),
    .wdata       (wdata)
);

// File: tb/evb_top_tb.sv
module evb_top_tb;

    localparam int unsigned NEV = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel_we = 1'b0;
    logic           data_we = 1'b0;
    logic           data_re = 1'b0;
    logic [63:0]    wdata = '0;
    logic [63:0]    rdata;
    logic           rvalid;
    logic [NEV-1:0] ev_inc = '0;
    logic           irq;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    evb_top #(.NUM_EV(NEV)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sel_we),
        .data_we (data_we),
        .data_re (data_re),
        .wdata   (wdata),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .ev_inc  (ev_inc),
        .irq     (irq)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: each read response is matched against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(rdata, 64'hDEAD, "R2 unexpected response");
            end else begin
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // All tasks are entered and left at a falling edge.
    task automatic set_sel(input logic [11:0] a);
        sel_we = 1'b1; wdata = {52'b0, a};
        @(negedge clk);
        sel_we = 1'b0; wdata = '0;
    endtask

    task automatic wr(input logic [63:0] v);
        data_we = 1'b1; wdata = v;
        @(negedge clk);
        data_we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [63:0] e, input string t);
        data_re = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        data_re = 1'b0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [63:0] v);
        set_sel(a); wr(v);
    endtask

    task automatic rreg(input logic [11:0] a, input logic [63:0] e, input string t);
        set_sel(a); rd(e, t);
    endtask

    task automatic pulse(input logic [NEV-1:0] m, input int unsigned k);
        ev_inc = m;
        repeat (k) @(negedge clk);
        ev_inc = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({63'b0, irq}, 64'd0, "R1 irq");
        check({63'b0, rvalid}, 64'd0, "R1 rvalid");
        rreg(12'h400, 64'h2000, "R3 control count field");
        rreg(12'h40A, 64'd0, "R1 cycle counter");
        rreg(12'h408, 64'd0, "R1 overflow");
        rreg(12'h404, 64'd0, "R1 count enable");

        // R2 unmapped addresses
        rreg(12'h401, 64'd0, "R2 unmapped 0x401");
        rreg(12'h461, 64'd0, "R2 unmapped counter slot");
        wreg(12'h461, 64'h55);
        rreg(12'h421, 64'd0, "R2 write to unmapped ignored");

        // R5 count enable mask
        wreg(12'h404, 64'hFFFF_FFFF);
        rreg(12'h403, 64'h8000_000F, "R5 set all");
        wreg(12'h403, 64'h2);
        rreg(12'h404, 64'h8000_000D, "R5 clear one");
        wreg(12'h403, 64'hFFFF_FFFF);
        rreg(12'h404, 64'd0, "R5 clear all");
        wreg(12'h404, 64'h8000_0001);

        // R6 interrupt enable mask
        wreg(12'h406, 64'hFFFF_FFF0);
        rreg(12'h405, 64'h8000_0000, "R6 set");
        wreg(12'h405, 64'h8000_0000);
        wreg(12'h406, 64'h1);
        rreg(12'h405, 64'h1, "R6 clear and set");

        // R13 count-control storage
        wreg(12'h420, 64'hA5);
        wreg(12'h430, 64'h5A);
        rreg(12'h420, 64'hA5, "R13 ctl0");
        rreg(12'h430, 64'h5A, "R13 ctl1");

        // R7 no counting while globally stopped
        pulse(4'hF, 5);
        rreg(12'h421, 64'd0, "R7 global off");

        // R7 R8 counting: 5 increments; cycle counter sees 5 + 2 enabled edges
        wreg(12'h400, 64'h1);
        pulse(4'b0011, 5);
        wreg(12'h400, 64'h0);
        rreg(12'h421, 64'd5, "R7 R13 counter0 counts");
        rreg(12'h431, 64'd0, "R7 counter1 enable clear");
        rreg(12'h40A, 64'd7, "R8 cycle count");
        rreg(12'h400, 64'h2000, "R3 run bit cleared");

        // R9 R10 preload and wrap of an event counter
        wreg(12'h421, 64'hFFFF_FFFE);
        rreg(12'h421, 64'hFFFF_FFFE, "R9 preload");
        wreg(12'h400, 64'h1);
        pulse(4'b0001, 3);
        wreg(12'h400, 64'h0);
        rreg(12'h421, 64'd1, "R10 wrapped value");
        rreg(12'h408, 64'h1, "R10 overflow bit0");
        check({63'b0, irq}, 64'd1, "R12 irq on enabled overflow");
        rreg(12'h40A, 64'd12, "R8 cycle count resumes");

        // R11 R12 overflow clear and set
        wreg(12'h407, 64'h1);
        check({63'b0, irq}, 64'd0, "R12 irq drops on clear");
        rreg(12'h408, 64'd0, "R11 cleared");
        wreg(12'h408, 64'h8000_0000);
        check({63'b0, irq}, 64'd0, "R12 masked overflow");
        rreg(12'h407, 64'h8000_0000, "R11 set via set address");
        wreg(12'h406, 64'h8000_0000);
        check({63'b0, irq}, 64'd1, "R12 irq on enable");
        wreg(12'h407, 64'h8000_0000);
        check({63'b0, irq}, 64'd0, "R11 clear bit31");

        // R10 cycle counter wrap over 64 bits
        wreg(12'h40A, 64'hFFFF_FFFF_FFFF_FFFF);
        wreg(12'h400, 64'h1);
        wreg(12'h400, 64'h0);
        rreg(12'h40A, 64'd1, "R10 cycle wrap value");
        rreg(12'h408, 64'h8000_0000, "R10 overflow bit31");
        check({63'b0, irq}, 64'd1, "R12 irq from cycle overflow");
        wreg(12'h407, 64'hFFFF_FFFF);

        // R9 load wins over a simultaneous increment
        wreg(12'h400, 64'h1);
        set_sel(12'h421);
        ev_inc = 4'b0001;
        wr(64'h100);
        ev_inc = '0;
        wreg(12'h400, 64'h0);
        rreg(12'h421, 64'h100, "R9 load beats increment");

        // R4 selective and full counter reset
        wreg(12'h40A, 64'd9);
        wreg(12'h421, 64'd5);
        wreg(12'h400, 64'h2);
        rreg(12'h421, 64'd0, "R4 event counters cleared");
        rreg(12'h40A, 64'd9, "R4 cycle counter kept");
        wreg(12'h400, 64'h6);
        rreg(12'h40A, 64'd0, "R4 cycle counter cleared");
        rreg(12'h400, 64'h2000, "R4 reset bits not stored");

        repeat (3) @(negedge clk);
        check(64'(exp_q.size()), 64'd0, "R2 every read answered");
        finish_run();
    end

endmodule